// File: doc/BRIEF.md
# Configurable-frame UART transceiver core

This core holds one asynchronous serial transmitter and one receiver that share a 16-bit mode register. That register sets the whole frame: a 4-bit frame-length field, parity on or off, even or odd parity, and one or two stop bits. The frame-length field counts every bit after the start bit, so it covers data, parity and stop bits together. The core works out the number of data bits from that field and the parity and stop settings. A single-cycle oversampling enable, pulsing at 16 times the bit rate, drives both directions. Each bit therefore lasts 16 ticks.

The buffer logic around the core hands characters to the transmitter with a valid/ready pair. It watches `tx_busy_o` to learn when a frame is on the line. Received characters come out as a one-cycle `rx_valid_o` pulse, but only while the buffer logic says it has room (`rx_space_i`). Five conditions are collected in a sticky event register: transmit done, receive done, character lost, break received and break end. A mask register selects which events drive `irq_o`. Software reaches the three registers through a simple write strobe and a combinational read port. It changes the format fields only while both enables are off.

Top module: `cfg_uart_core`

## Requirements
- R1: After reset, `txd_o` is 1, `tx_busy_o`, `rx_valid_o` and `irq_o` are 0, and all three registers read 0. The registers are at address 0 (mode), 1 (event) and 2 (mask). A write to address 0 stores all 16 bits and reads back unchanged.
- R2: The mode register fields are placed as follows:
  - bits 14:11 hold the frame length F;
  - bit 10 selects two stop bits;
  - bit 9 enables parity;
  - bit 8 selects the parity sense;
  - bits 5:4 hold the mode;
  - bits 3:2 hold the diagnostic field;
  - bit 1 enables transmit;
  - bit 0 enables receive.

  The number of data bits N is F − parity − (2 if two stop bits, else 1), and legal values of N run from 5 to 14. Each transmitted frame is sent in this order: a low start bit, N data bits LSB first, the parity bit if enabled, then one or two high stop bits. Every bit lasts 16 ticks. The start bit begins on the cycle after `tx_valid_i` is accepted.
- R3: With bit 8 = 1, parity is even and the parity bit is the XOR of the data bits. With bit 8 = 0, parity is odd and the parity bit is the inverse of that XOR. The transmitter sends this bit and the receiver checks against the same rule.
- R4: The transmitter accepts a character only when bits 5:4 = 2'b10, bits 3:2 = 2'b00 and bit 1 = 1. In any other setting `tx_ready_o` is 0 and `txd_o` stays high.
- R5: `tx_busy_o` is high from the first cycle of the start bit through the last stop bit, and low afterwards. When a frame ends, event bit 1 (transmit done) is set.
- R6: The receiver samples each bit at the middle of its 16 ticks. On a good stop bit it pulses `rx_valid_o` for one cycle with the data, zero-extended above N, on `rx_data_o`. It raises `rx_perr_o` when parity is enabled and the received parity bit breaks the R3 rule. It also sets event bit 0 (receive done).
- R7: A low pulse on `rxd_i` that has ended by the middle of the start bit is discarded: no character and no event follow.
- R8: A character that completes while `rx_space_i` is 0 is dropped. No `rx_valid_o` pulse is given and event bit 2 (lost) is set.
- R9: A frame in which all data bits, the parity bit and the stop bit are low is a break. It sets event bit 5 and gives no `rx_valid_o`. When `rxd_i` later returns high, event bit 6 (break end) is set.
- R10: A frame whose stop bit is low but which is not a break is delivered with `rx_ferr_o` = 1. The receiver then waits for the line to go high before it looks for a new start bit.
- R11: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle as its clear keeps the bit set. Only bits 6, 5, 2, 1 and 0 exist; all other bits read 0.
- R12: `irq_o` is 1 exactly when some event bit and the same mask bit are both 1.
- R13: The receiver takes characters only when bits 5:4 = 2'b10, bits 3:2 = 2'b00 and bit 0 = 1. Otherwise a full frame on `rxd_i` gives no `rx_valid_o` and no receive event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oversampling enable, 16 per bit time |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 mode, 1 event, 2 mask |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Masked event interrupt |
| tx_valid_i | input | 1 | Character offered to the transmitter |
| tx_data_i | input | 14 | Character to send, LSB first |
| tx_ready_o | output | 1 | Transmitter idle and enabled |
| tx_busy_o | output | 1 | Frame in progress on the line |
| txd_o | output | 1 | Serial output, idle high |
| rxd_i | input | 1 | Serial input |
| rx_space_i | input | 1 | Buffer logic can take a character |
| rx_valid_o | output | 1 | One-cycle pulse with a received character |
| rx_data_o | output | 14 | Received character |
| rx_perr_o | output | 1 | Parity error on the delivered character |
| rx_ferr_o | output | 1 | Low stop bit on the delivered character |

## Verification
The hardest paths to reach are in the receiver's stop-bit handling, where three outcomes have to be told apart: a break, a framing error and a normal character. A break-end event requires the receiver to stay parked in its wait-for-high state across a long low stretch. The bench drives `rxd_i` bit by bit from its own frame generator. This lets it create frames a transmitter would never send: wrong parity, a low stop bit after nonzero data, and a low level held for more than twelve bit times. It then releases the line and reads the event register between each step, so break and break end are checked one at a time. A short low glitch and a frame sent with the buffer full cover the paths that must leave no character behind.

// File: rtl/cfg_uart_pkg.sv
package cfg_uart_pkg;

    // mode register field positions (decoded by the frame logic)
    localparam int FLEN_LO  = 11;
    localparam int FLEN_HI  = 14;
    localparam int STOP2_B  = 10;
    localparam int PEN_B    = 9;
    localparam int PEVEN_B  = 8;
    localparam int MODE_LO  = 4;
    localparam int MODE_HI  = 5;
    localparam int DIAG_LO  = 2;
    localparam int DIAG_HI  = 3;
    localparam int TXEN_B   = 1;
    localparam int RXEN_B   = 0;

    localparam logic [1:0] MODE_ASYNC = 2'b10;
    localparam logic [1:0] DIAG_NORM  = 2'b00;

    // width of the frame-length field and of bit counters
    localparam int BCW = 4;

    // event register
    localparam int EVW        = 7;
    localparam int EV_RXDONE  = 0;
    localparam int EV_TXDONE  = 1;
    localparam int EV_LOST    = 2;
    localparam int EV_BRK     = 5;
    localparam int EV_BRKEND  = 6;
    localparam logic [EVW-1:0] EV_IMPL = 7'b110_0111;

    // register addresses
    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_EVT  = 2'd1;
    localparam logic [1:0] A_MASK = 2'd2;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI
    } rx_state_e;

endpackage

// File: rtl/uart_fmt_dec.sv
module uart_fmt_dec
    import cfg_uart_pkg::*;
#(
    parameter int DMAX = 14
) (
    input  logic [BCW-1:0]  flen_i,
    input  logic            two_stop_i,
    input  logic            pen_i,
    input  logic [1:0]      mode_i,
    input  logic [1:0]      diag_i,
    input  logic            ten_i,
    input  logic            ren_i,
    output logic [BCW-1:0]  dbits_o,
    output logic [DMAX-1:0] dmask_o,
    output logic            tx_en_o,
    output logic            rx_en_o
);

    logic [BCW:0] dcount;
    logic         active;

    always_comb begin
        // data bits = frame length - parity bit - stop bits
        dcount = {1'b0, flen_i}
               - {{BCW{1'b0}}, pen_i}
               - (two_stop_i ? (BCW+1)'(2) : (BCW+1)'(1));
        dbits_o = dcount[BCW-1:0];
        for (int i = 0; i < DMAX; i++) begin
            dmask_o[i] = (32'(i) < 32'(dbits_o));
        end
        active  = (mode_i == MODE_ASYNC) && (diag_i == DIAG_NORM);
        tx_en_o = active && ten_i;
        rx_en_o = active && ren_i;
    end

endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import cfg_uart_pkg::*;
#(
    parameter int DMAX = 14,
    parameter int OSR  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            en_i,
    input  logic [BCW-1:0]  dbits_i,
    input  logic [DMAX-1:0] dmask_i,
    input  logic            pen_i,
    input  logic            pm_i,
    input  logic            two_stop_i,
    input  logic            tx_valid_i,
    input  logic [DMAX-1:0] tx_data_i,
    output logic            tx_ready_o,
    output logic            tx_busy_o,
    output logic            txd_o,
    output logic            tx_done_o
);

    localparam int CW = $clog2(OSR);

    typedef struct packed {
        tx_state_e       st;
        logic [CW-1:0]   cnt;
        logic [BCW-1:0]  bitn;
        logic [DMAX-1:0] sh;
        logic            par;
        logic            done;
    } tx_reg_t;

    tx_reg_t q, d;
    logic [DMAX-1:0] load;

    always_comb begin
        load = tx_data_i & dmask_i;
        d      = q;
        d.done = 1'b0;
        if (!en_i) begin
            d.st  = TX_IDLE;
            d.cnt = '0;
        end else if (q.st == TX_IDLE) begin
            if (tx_valid_i) begin
                d.st   = TX_START;
                d.cnt  = '0;
                d.bitn = '0;
                d.sh   = load;
                d.par  = pm_i ? (^load) : ~(^load);
            end
        end else if (tick_i) begin
            if (q.cnt == CW'(OSR-1)) begin
                d.cnt = '0;
                case (q.st)
                    TX_START: begin
                        d.st   = TX_DATA;
                        d.bitn = '0;
                    end
                    TX_DATA: begin
                        d.sh = q.sh >> 1;
                        if (q.bitn == dbits_i - BCW'(1)) begin
                            d.bitn = '0;
                            d.st   = pen_i ? TX_PAR : TX_STOP;
                        end else begin
                            d.bitn = q.bitn + BCW'(1);
                        end
                    end
                    TX_PAR: begin
                        d.st   = TX_STOP;
                        d.bitn = '0;
                    end
                    TX_STOP: begin
                        if (two_stop_i && (q.bitn == '0)) begin
                            d.bitn = BCW'(1);
                        end else begin
                            d.st   = TX_IDLE;
                            d.done = 1'b1;
                        end
                    end
                    default: d.st = TX_IDLE;
                endcase
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (q.st)
            TX_START: txd_o = 1'b0;
            TX_DATA:  txd_o = q.sh[0];
            TX_PAR:   txd_o = q.par;
            default:  txd_o = 1'b1;
        endcase
    end

    assign tx_ready_o = en_i && (q.st == TX_IDLE);
    assign tx_busy_o  = (q.st != TX_IDLE);
    assign tx_done_o  = q.done;

    // R2: the first busy cycle drives the start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy_o) |-> !txd_o);

    // R5: frame completion only follows a busy frame
    p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_o |-> ($past(tx_busy_o) && !tx_busy_o));

endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import cfg_uart_pkg::*;
#(
    parameter int DMAX = 14,
    parameter int OSR  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            en_i,
    input  logic [BCW-1:0]  dbits_i,
    input  logic            pen_i,
    input  logic            pm_i,
    input  logic            rxd_i,
    input  logic            rx_space_i,
    output logic            rx_valid_o,
    output logic [DMAX-1:0] rx_data_o,
    output logic            rx_perr_o,
    output logic            rx_ferr_o,
    output logic            ev_done_o,
    output logic            ev_lost_o,
    output logic            ev_brk_o,
    output logic            ev_brke_o
);

    localparam int CW  = $clog2(OSR);
    localparam int MID = OSR/2 - 1;

    typedef struct packed {
        rx_state_e       st;
        logic [CW-1:0]   cnt;
        logic [BCW-1:0]  bitn;
        logic [DMAX-1:0] sh;
        logic            pbit;
        logic            allz;
        logic            brk;
        logic            sy1;
        logic            sy2;
        logic            valid;
        logic [DMAX-1:0] data;
        logic            perr;
        logic            ferr;
        logic            ev_done;
        logic            ev_lost;
        logic            ev_brk;
        logic            ev_brke;
    } rx_reg_t;

    localparam rx_reg_t RX_RST = '{st: RX_IDLE, sy1: 1'b1, sy2: 1'b1, default: '0};

    rx_reg_t q, d;
    logic    exp_par;

    always_comb begin
        exp_par   = pm_i ? (^q.sh) : ~(^q.sh);
        d         = q;
        d.sy1     = rxd_i;
        d.sy2     = q.sy1;
        d.valid   = 1'b0;
        d.ev_done = 1'b0;
        d.ev_lost = 1'b0;
        d.ev_brk  = 1'b0;
        d.ev_brke = 1'b0;
        if (!en_i) begin
            d.st  = RX_IDLE;
            d.brk = 1'b0;
        end else begin
            case (q.st)
                RX_IDLE: begin
                    if (tick_i && !q.sy2) begin
                        d.st   = RX_START;
                        d.cnt  = '0;
                        d.bitn = '0;
                        d.sh   = '0;
                        d.allz = 1'b1;
                    end
                end
                RX_WAITHI: begin
                    if (q.sy2) begin
                        d.st      = RX_IDLE;
                        d.ev_brke = q.brk;
                        d.brk     = 1'b0;
                    end
                end
                default: begin
                    if (tick_i) begin
                        d.cnt = (q.cnt == CW'(OSR-1)) ? '0 : q.cnt + CW'(1);
                        if (q.cnt == CW'(MID)) begin
                            case (q.st)
                                RX_START: if (q.sy2) d.st = RX_IDLE;
                                RX_DATA: begin
                                    d.sh[q.bitn] = q.sy2;
                                    if (q.sy2) d.allz = 1'b0;
                                end
                                RX_PAR: begin
                                    d.pbit = q.sy2;
                                    if (q.sy2) d.allz = 1'b0;
                                end
                                RX_STOP: begin
                                    if (!q.sy2 && q.allz) begin
                                        d.brk    = 1'b1;
                                        d.ev_brk = 1'b1;
                                        d.st     = RX_WAITHI;
                                    end else begin
                                        if (rx_space_i) begin
                                            d.valid   = 1'b1;
                                            d.data    = q.sh;
                                            d.perr    = pen_i && (q.pbit != exp_par);
                                            d.ferr    = !q.sy2;
                                            d.ev_done = 1'b1;
                                        end else begin
                                            d.ev_lost = 1'b1;
                                        end
                                        d.st = q.sy2 ? RX_IDLE : RX_WAITHI;
                                    end
                                end
                                default: ;
                            endcase
                        end
                        if (q.cnt == CW'(OSR-1)) begin
                            case (q.st)
                                RX_START: begin
                                    d.st   = RX_DATA;
                                    d.bitn = '0;
                                end
                                RX_DATA: begin
                                    if (q.bitn == dbits_i - BCW'(1)) begin
                                        d.st = pen_i ? RX_PAR : RX_STOP;
                                    end else begin
                                        d.bitn = q.bitn + BCW'(1);
                                    end
                                end
                                RX_PAR:  d.st = RX_STOP;
                                default: ;
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RX_RST;
        else        q <= d;
    end

    assign rx_valid_o = q.valid;
    assign rx_data_o  = q.data;
    assign rx_perr_o  = q.perr;
    assign rx_ferr_o  = q.ferr;
    assign ev_done_o  = q.ev_done;
    assign ev_lost_o  = q.ev_lost;
    assign ev_brk_o   = q.ev_brk;
    assign ev_brke_o  = q.ev_brke;

    // R6: a delivered character is a single-cycle pulse
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R8: delivery only happens when the buffer logic had room
    p_valid_space_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $past(rx_space_i));

    // R9: a break never produces a character
    p_brk_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_brk_o |-> !rx_valid_o);

endmodule

// File: rtl/uart_evt.sv
module uart_evt
    import cfg_uart_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EVW-1:0] set_i,
    input  logic           wr_evt_i,
    input  logic           wr_mask_i,
    input  logic [EVW-1:0] wdata_i,
    output logic [EVW-1:0] evt_o,
    output logic [EVW-1:0] mask_o,
    output logic           irq_o
);

    typedef struct packed {
        logic [EVW-1:0] evt;
        logic [EVW-1:0] mask;
    } evt_reg_t;

    evt_reg_t q, d;
    logic [EVW-1:0] clr;

    always_comb begin
        clr    = wr_evt_i ? wdata_i : '0;
        d      = q;
        d.evt  = ((q.evt & ~clr) | set_i) & EV_IMPL;
        if (wr_mask_i) d.mask = wdata_i & EV_IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign evt_o  = q.evt;
    assign mask_o = q.mask;
    assign irq_o  = |(q.evt & q.mask);

    // R11: writing one clears a bit that is not being set again
    p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt_i && wdata_i[EV_RXDONE] && !set_i[EV_RXDONE]) |=> !evt_o[EV_RXDONE]);

    // R11: a bit without a clear stays set
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o[EV_TXDONE] && !(wr_evt_i && wdata_i[EV_TXDONE])) |=> evt_o[EV_TXDONE]);

    // R11: set wins over a simultaneous clear
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[EV_LOST] |=> evt_o[EV_LOST]);

endmodule

// File: rtl/cfg_uart_core.sv
module cfg_uart_core
    import cfg_uart_pkg::*;
#(
    parameter int DMAX = 14,
    parameter int OSR  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            reg_wr_i,
    input  logic [1:0]      reg_addr_i,
    input  logic [15:0]     reg_wdata_i,
    output logic [15:0]     reg_rdata_o,
    output logic            irq_o,
    input  logic            tx_valid_i,
    input  logic [DMAX-1:0] tx_data_i,
    output logic            tx_ready_o,
    output logic            tx_busy_o,
    output logic            txd_o,
    input  logic            rxd_i,
    input  logic            rx_space_i,
    output logic            rx_valid_o,
    output logic [DMAX-1:0] rx_data_o,
    output logic            rx_perr_o,
    output logic            rx_ferr_o
);

    logic [15:0] mode_q, mode_d;

    logic [BCW-1:0]  dbits;
    logic [DMAX-1:0] dmask;
    logic            tx_en, rx_en;
    logic            tx_done;
    logic            ev_done, ev_lost, ev_brk, ev_brke;
    logic [EVW-1:0]  ev_set, evt, mask;

    always_comb begin
        mode_d = mode_q;
        if (reg_wr_i && (reg_addr_i == A_MODE)) mode_d = reg_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    uart_fmt_dec #(.DMAX(DMAX)) u_dec (
        .flen_i     (mode_q[FLEN_HI:FLEN_LO]),
        .two_stop_i (mode_q[STOP2_B]),
        .pen_i      (mode_q[PEN_B]),
        .mode_i     (mode_q[MODE_HI:MODE_LO]),
        .diag_i     (mode_q[DIAG_HI:DIAG_LO]),
        .ten_i      (mode_q[TXEN_B]),
        .ren_i      (mode_q[RXEN_B]),
        .dbits_o    (dbits),
        .dmask_o    (dmask),
        .tx_en_o    (tx_en),
        .rx_en_o    (rx_en)
    );

    uart_tx #(.DMAX(DMAX), .OSR(OSR)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .en_i       (tx_en),
        .dbits_i    (dbits),
        .dmask_i    (dmask),
        .pen_i      (mode_q[PEN_B]),
        .pm_i       (mode_q[PEVEN_B]),
        .two_stop_i (mode_q[STOP2_B]),
        .tx_valid_i (tx_valid_i),
        .tx_data_i  (tx_data_i),
        .tx_ready_o (tx_ready_o),
        .tx_busy_o  (tx_busy_o),
        .txd_o      (txd_o),
        .tx_done_o  (tx_done)
    );

    uart_rx #(.DMAX(DMAX), .OSR(OSR)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .en_i       (rx_en),
        .dbits_i    (dbits),
        .pen_i      (mode_q[PEN_B]),
        .pm_i       (mode_q[PEVEN_B]),
        .rxd_i      (rxd_i),
        .rx_space_i (rx_space_i),
        .rx_valid_o (rx_valid_o),
        .rx_data_o  (rx_data_o),
        .rx_perr_o  (rx_perr_o),
        .rx_ferr_o  (rx_ferr_o),
        .ev_done_o  (ev_done),
        .ev_lost_o  (ev_lost),
        .ev_brk_o   (ev_brk),
        .ev_brke_o  (ev_brke)
    );

    always_comb begin
        ev_set             = '0;
        ev_set[EV_RXDONE]  = ev_done;
        ev_set[EV_TXDONE]  = tx_done;
        ev_set[EV_LOST]    = ev_lost;
        ev_set[EV_BRK]     = ev_brk;
        ev_set[EV_BRKEND]  = ev_brke;
    end

    uart_evt u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (ev_set),
        .wr_evt_i  (reg_wr_i && (reg_addr_i == A_EVT)),
        .wr_mask_i (reg_wr_i && (reg_addr_i == A_MASK)),
        .wdata_i   (reg_wdata_i[EVW-1:0]),
        .evt_o     (evt),
        .mask_o    (mask),
        .irq_o     (irq_o)
    );

    always_comb begin
        case (reg_addr_i)
            A_MODE:  reg_rdata_o = mode_q;
            A_EVT:   reg_rdata_o = {{(16-EVW){1'b0}}, evt};
            A_MASK:  reg_rdata_o = {{(16-EVW){1'b0}}, mask};
            default: reg_rdata_o = '0;
        endcase
    end

    // R4: the transmitter offers readiness only in enabled asynchronous mode
    p_ready_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> ((mode_q[MODE_HI:MODE_LO] == MODE_ASYNC)
                        && (mode_q[DIAG_HI:DIAG_LO] == DIAG_NORM)
                        && mode_q[TXEN_B]));

endmodule

// File: tb/cfg_uart_core_tb.sv
module cfg_uart_core_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    logic        tx_valid = 1'b0;
    logic [13:0] tx_data = '0;
    logic        tx_ready, tx_busy, txd;
    logic        rxd = 1'b1;
    logic        rx_space = 1'b1;
    logic        rx_valid;
    logic [13:0] rx_data;
    logic        rx_perr, rx_ferr;

    int nchk = 0;
    int nerr = 0;
    int got_cnt = 0;
    logic [13:0] got_data = '0;
    logic        got_perr = 1'b0;
    logic        got_ferr = 1'b0;

    cfg_uart_core u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq),
        .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
        .tx_busy_o(tx_busy), .txd_o(txd),
        .rxd_i(rxd), .rx_space_i(rx_space), .rx_valid_o(rx_valid),
        .rx_data_o(rx_data), .rx_perr_o(rx_perr), .rx_ferr_o(rx_ferr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rx_valid) begin
            got_cnt  = got_cnt + 1;
            got_data = rx_data;
            got_perr = rx_perr;
            got_ferr = rx_ferr;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_mode(input logic [3:0] flen, input logic two,
        input logic pen, input logic pm, input logic ten, input logic ren,
        input logic [1:0] mf, input logic [1:0] dg);
        return {1'b0, flen, two, pen, pm, 2'b00, mf, dg, ten, ren};
    endfunction

    function automatic logic par_of(input logic [13:0] v, input logic even);
        return even ? (^v) : ~(^v);
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic drive_bit(input logic v);
        @(negedge clk);
        rxd = v;
        repeat (15) @(negedge clk);
    endtask

    task automatic send_frame(input int n, input logic pen, input logic pbit,
                              input logic stopv, input logic [13:0] data);
        drive_bit(1'b0);
        for (int i = 0; i < n; i++) drive_bit(data[i]);
        if (pen) drive_bit(pbit);
        drive_bit(stopv);
        @(negedge clk);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 txd idle", txd, 1);
        chk("R1 busy", tx_busy, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 irq", irq, 0);
        reg_read(2'd0, v); chk("R1 mode reg", v, 0);
        reg_read(2'd1, v); chk("R1 event reg", v, 0);
        reg_read(2'd2, v); chk("R1 mask reg", v, 0);
        reg_write(2'd0, 16'hA5C3);
        reg_read(2'd0, v); chk("R1 mode readback", v, 16'hA5C3);
        reg_write(2'd0, 16'h0000);
    endtask

    task automatic t_tx(input logic [3:0] flen, input logic two, input logic pen,
                        input logic pm, input logic [13:0] data);
        int n;
        int ns;
        logic [15:0] v;
        n  = int'(flen) - int'(pen) - (two ? 2 : 1);
        ns = two ? 2 : 1;
        reg_write(2'd0, mk_mode(flen, two, pen, pm, 1'b1, 1'b0, 2'b10, 2'b00));
        reg_write(2'd1, 16'h007F);
        @(negedge clk);
        chk("R4 ready when enabled", tx_ready, 1);
        tx_valid = 1'b1; tx_data = data;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (7) @(negedge clk);
        chk("R2 start bit", txd, 0);
        chk("R5 busy at start", tx_busy, 1);
        for (int i = 0; i < n; i++) begin
            repeat (16) @(negedge clk);
            chk("R2 data bit", txd, data[i]);
        end
        if (pen) begin
            repeat (16) @(negedge clk);
            chk("R3 parity bit", txd, par_of(data, pm));
        end
        for (int s = 0; s < ns; s++) begin
            repeat (16) @(negedge clk);
            chk("R2 stop bit", txd, 1);
            chk("R5 busy in stop", tx_busy, 1);
        end
        repeat (10) @(negedge clk);
        chk("R5 busy after frame", tx_busy, 0);
        chk("R2 line idle after frame", txd, 1);
        reg_read(2'd1, v);
        chk("R5 tx done event", v[1], 1);
        reg_write(2'd1, 16'h007F);
    endtask

    task automatic t_tx_disabled();
        reg_write(2'd0, mk_mode(4'd9, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 2'b00));
        @(negedge clk);
        chk("R4 ready with wrong mode", tx_ready, 0);
        reg_write(2'd0, mk_mode(4'd9, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 2'b01));
        @(negedge clk);
        chk("R4 ready with diag set", tx_ready, 0);
        tx_valid = 1'b1; tx_data = 14'h0000;
        repeat (40) @(negedge clk);
        tx_valid = 1'b0;
        chk("R4 line stays high", txd, 1);
        chk("R4 never busy", tx_busy, 0);
    endtask

    task automatic t_rx_good();
        int c0;
        logic [15:0] v;
        reg_write(2'd0, mk_mode(4'd10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 2'b00));
        reg_write(2'd1, 16'h007F);
        c0 = got_cnt;
        send_frame(8, 1'b1, par_of(14'h00A5, 1'b1), 1'b1, 14'h00A5);
        chk("R6 one char", got_cnt, c0 + 1);
        chk("R6 data", got_data, 14'h00A5);
        chk("R6 parity ok", got_perr, 0);
        chk("R6 no ferr", got_ferr, 0);
        reg_read(2'd1, v); chk("R6 rx done event", v[0], 1);
        send_frame(8, 1'b1, ~par_of(14'h0033, 1'b1), 1'b1, 14'h0033);
        chk("R6 second char", got_cnt, c0 + 2);
        chk("R6 data two", got_data, 14'h0033);
        chk("R3 parity error flagged", got_perr, 1);
        // odd parity, 5 data bits, two stop bits
        reg_write(2'd0, mk_mode(4'd8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 2'b00));
        send_frame(5, 1'b1, par_of(14'h0016, 1'b0), 1'b1, 14'h0016);
        chk("R6 five bit char", got_data, 14'h0016);
        chk("R3 odd parity ok", got_perr, 0);
    endtask

    task automatic t_rx_glitch();
        int c0;
        logic [15:0] v;
        reg_write(2'd0, mk_mode(4'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 2'b00));
        reg_write(2'd1, 16'h007F);
        c0 = got_cnt;
        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk); rxd = 1'b1;
        repeat (300) @(negedge clk);
        chk("R7 glitch no char", got_cnt, c0);
        reg_read(2'd1, v); chk("R7 glitch no event", v, 0);
        send_frame(8, 1'b0, 1'b0, 1'b1, 14'h00C6);
        chk("R7 next frame received", got_data, 14'h00C6);
    endtask

    task automatic t_rx_nospace();
        int c0;
        logic [15:0] v;
        reg_write(2'd1, 16'h007F);
        rx_space = 1'b0;
        c0 = got_cnt;
        send_frame(8, 1'b0, 1'b0, 1'b1, 14'h005A);
        rx_space = 1'b1;
        chk("R8 no char without space", got_cnt, c0);
        reg_read(2'd1, v);
        chk("R8 lost event", v[2], 1);
        chk("R8 no rx done", v[0], 0);
    endtask

    task automatic t_break();
        int c0;
        logic [15:0] v;
        reg_write(2'd0, mk_mode(4'd10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 2'b00));
        reg_write(2'd1, 16'h007F);
        c0 = got_cnt;
        @(negedge clk); rxd = 1'b0;
        repeat (16*13) @(negedge clk);
        reg_read(2'd1, v);
        chk("R9 break event", v[5], 1);
        chk("R9 no break end yet", v[6], 0);
        chk("R9 no char on break", got_cnt, c0);
        @(negedge clk); rxd = 1'b1;
        repeat (6) @(negedge clk);
        reg_read(2'd1, v);
        chk("R9 break end event", v[6], 1);
    endtask

    task automatic t_ferr();
        int c0;
        reg_write(2'd0, mk_mode(4'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 2'b00));
        c0 = got_cnt;
        send_frame(8, 1'b0, 1'b0, 1'b0, 14'h003C);
        chk("R10 char delivered", got_cnt, c0 + 1);
        chk("R10 data", got_data, 14'h003C);
        chk("R10 framing flag", got_ferr, 1);
        send_frame(8, 1'b0, 1'b0, 1'b1, 14'h0081);
        chk("R10 recovers", got_data, 14'h0081);
        chk("R10 ferr cleared", got_ferr, 0);
    endtask

    task automatic t_events();
        logic [15:0] v;
        reg_write(2'd1, 16'h007F);
        reg_write(2'd2, 16'h0000);
        send_frame(8, 1'b0, 1'b0, 1'b1, 14'h0011);
        @(negedge clk);
        chk("R12 irq masked off", irq, 0);
        reg_write(2'd2, 16'h0001);
        chk("R12 irq with mask", irq, 1);
        reg_write(2'd1, 16'h0002);
        reg_read(2'd1, v);
        chk("R11 zero write keeps bit", v[0], 1);
        reg_write(2'd1, 16'h0001);
        reg_read(2'd1, v);
        chk("R11 write one clears", v[0], 0);
        chk("R12 irq drops", irq, 0);
        reg_write(2'd2, 16'hFFFF);
        reg_read(2'd2, v);
        chk("R11 only implemented bits", v, 16'h0067);
        reg_write(2'd2, 16'h0000);
    endtask

    task automatic t_rx_disabled();
        int c0;
        logic [15:0] v;
        reg_write(2'd0, mk_mode(4'd9, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 2'b00));
        reg_write(2'd1, 16'h007F);
        c0 = got_cnt;
        send_frame(8, 1'b0, 1'b0, 1'b1, 14'h0077);
        chk("R13 no char when disabled", got_cnt, c0);
        reg_read(2'd1, v);
        chk("R13 no rx event", v[0], 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nerr++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx(4'd9,  1'b0, 1'b0, 1'b0, 14'h00B4);
        t_tx(4'd9,  1'b0, 1'b1, 1'b1, 14'h005D);
        t_tx(4'd11, 1'b1, 1'b1, 1'b0, 14'h00E1);
        t_tx(4'd7,  1'b1, 1'b0, 1'b0, 14'h0013);
        t_tx(4'd15, 1'b0, 1'b0, 1'b0, 14'h2A5B);
        t_tx_disabled();
        t_rx_good();
        t_rx_glitch();
        t_rx_nospace();
        t_break();
        t_ferr();
        t_events();
        t_rx_disabled();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule